// File: doc/BRIEF.md
# Multi-Source Reset and Start-Up Sequencer

This block walks a device through three phases: supply reset, held reset (which includes the start-up window), and normal operation. The supply-good flag from an external power-on comparator acts as the deepest reset. It forces the supply-reset phase asynchronously and from any state. Two further sources return the device to the held-reset phase: an active-low hard reset pin, filtered for a minimum low time, and a soft-reset command byte decoded from a management bus.

After any reset, the block times a start-up window in clock cycles. The window runs ten times longer if a flash log integrity check reports a failure while the window is open. The phase also decides how two classes of pins are driven. Pulse-width-modulated pins are pulled low while in held reset. General pins are released so that they act as inputs. In normal operation both classes follow the application's requests.

Top module: `rst_seq_top`

## Requirements
- R1: While `supplyGood` is low, `phase` is 0 (supply reset) and `ready` is 0, with effect at once and without waiting for a clock edge.
- R2: On the first clock edge with `supplyGood` high after supply reset, `phase` becomes 1 (held reset) and the start-up timer starts from zero.
- R3: With no failure report, `phase` becomes 2 (run) on the edge that comes CLK_KHZ*INIT_MS edges after the edge that entered start-up.
- R4: If `chkValid` and `chkFail` are both high on an edge during start-up, the window becomes CLK_KHZ*INIT_FAIL_MS edges instead. A report with `chkFail` low keeps the short window.
- R5: In start-up or run, a low `rstPinN` is ignored when it is sampled on at most TRST_CYC = CLK_KHZ*TRST_US/1000 consecutive edges. On the (TRST_CYC+1)th consecutive low edge the block enters held reset. It stays there while the pin is low, and start-up begins on the first edge where the pin is high.
- R6: When `cmdValid` is high with `cmdByte` = 8'hDB in start-up or run, start-up restarts on that edge. Any other byte has no effect.
- R7: The hard reset pin is ignored while `supplyValid` is low.
- R8: In held reset, every `pwmOe` bit is 1, every `pwmLvl` bit is 0 and every `gpioOe` bit is 0.
- R9: In supply reset, every `pwmOe` and `gpioOe` bit is 0.
- R10: In run, `pwmOe` is all ones, `pwmLvl` equals `pwmReq`, `gpioOe` equals `gpioOeReq` and `gpioOut` equals `gpioOutReq`.
- R11: A hard or soft reset during start-up restarts the timer from zero and clears any earlier failure report.
- R12: `ready` is a register that is high exactly when `phase` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supplyGood | input | 1 | Supply above reset threshold; low is an asynchronous reset |
| supplyValid | input | 1 | Supply inside operating range; enables the hard reset pin |
| rstPinN | input | 1 | Active-low hard reset pin (synchronous to clk) |
| cmdValid | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command byte; 8'hDB requests a soft reset |
| chkValid | input | 1 | Integrity check result strobe |
| chkFail | input | 1 | Integrity check reported a failure |
| pwmReq | input | NUM_PWM | Requested PWM pin levels in run |
| gpioOeReq | input | NUM_GPIO | Requested general pin output enables in run |
| gpioOutReq | input | NUM_GPIO | Requested general pin levels in run |
| phase | output | 2 | 0 supply reset, 1 held reset, 2 run |
| ready | output | 1 | Registered normal-operation flag |
| pwmOe | output | NUM_PWM | PWM pin output enables |
| pwmLvl | output | NUM_PWM | PWM pin levels |
| gpioOe | output | NUM_GPIO | General pin output enables |
| gpioOut | output | NUM_GPIO | General pin levels |

## Verification
Start-up timing is measured edge by edge after three different triggers: supply rise, soft command and hard pin release. Seeing the same window after each shows that every path clears the timer alike. Pin pulses of exactly the filter length and one edge longer separate a correct filter from an off-by-one. Random runs mix passing and failing integrity reports with random pin requests, which separates the short window from the long one and tests the pin muxing with varied data. Restarts in the middle of the window, wrong command bytes and pin activity while the supply is out of range each test one ignore or restart rule.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    PH_SUPPLY = 2'd0,
    PH_HELD   = 2'd1,
    PH_RUN    = 2'd2
  } phase_e;

  // strobes from the sequencer to the counters
  typedef struct packed {
    logic timerClr;
    logic timerRun;
    logic failClr;
    logic failArm;
  } seqCtl_t;

  // status from the counters back to the sequencer
  typedef struct packed {
    logic pinTrip;
    logic initDone;
  } seqStat_t;

  localparam logic [7:0] SOFT_RST_CODE = 8'hDB;

endpackage

// File: rtl/rst_seq_dp.sv
module rst_seq_dp
  import rst_seq_pkg::*;
#(
  parameter int INIT_CYC = 20,
  parameter int FAIL_CYC = 200,
  parameter int TRST_CYC = 6,
  parameter int NUM_PWM  = 4,
  parameter int NUM_GPIO = 8
) (
  input  logic                clk,
  input  logic                supplyGood,
  input  logic                supplyValid,
  input  logic                rstPinN,
  input  logic                chkValid,
  input  logic                chkFail,
  input  seqCtl_t             ctl,
  input  logic [1:0]          phaseIn,
  input  logic [NUM_PWM-1:0]  pwmReq,
  input  logic [NUM_GPIO-1:0] gpioOeReq,
  input  logic [NUM_GPIO-1:0] gpioOutReq,
  output seqStat_t            stat,
  output logic [NUM_PWM-1:0]  pwmOe,
  output logic [NUM_PWM-1:0]  pwmLvl,
  output logic [NUM_GPIO-1:0] gpioOe,
  output logic [NUM_GPIO-1:0] gpioOut
);

  localparam int TW = $clog2(TRST_CYC + 1);
  localparam int IW = $clog2(FAIL_CYC + 1);
  localparam logic [TW-1:0] PIN_LIMIT = TW'(TRST_CYC);
  localparam logic [IW-1:0] NORM_LAST = IW'(INIT_CYC - 1);
  localparam logic [IW-1:0] FAIL_LAST = IW'(FAIL_CYC - 1);

  // hard pin low-time filter
  logic [TW-1:0] pinCnt;
  logic          pinLow;

  assign pinLow = !rstPinN && supplyValid;

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood)            pinCnt <= '0;
    else if (!pinLow)           pinCnt <= '0;
    else if (pinCnt != PIN_LIMIT) pinCnt <= pinCnt + 1'b1;
  end

  assign stat.pinTrip = pinLow && (pinCnt == PIN_LIMIT);

  // start-up window timer and integrity result
  logic [IW-1:0] timer;
  logic          failFlag;
  logic          failHit;
  logic          failNow;

  assign failHit = ctl.failArm && chkValid && chkFail;
  assign failNow = failFlag || failHit;
  assign stat.initDone = (timer == (failNow ? FAIL_LAST : NORM_LAST));

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) begin
      timer    <= '0;
      failFlag <= 1'b0;
    end else begin
      if (ctl.timerClr)      timer <= '0;
      else if (ctl.timerRun) timer <= timer + 1'b1;
      if (ctl.failClr)       failFlag <= 1'b0;
      else if (failHit)      failFlag <= 1'b1;
    end
  end

  // pin class output policy
  for (genvar i = 0; i < NUM_PWM; i++) begin : gPwm
    always_comb begin
      pwmOe[i]  = (phaseIn != PH_SUPPLY);
      pwmLvl[i] = (phaseIn == PH_RUN) ? pwmReq[i] : 1'b0;
    end
  end

  for (genvar j = 0; j < NUM_GPIO; j++) begin : gGpio
    always_comb begin
      gpioOe[j]  = (phaseIn == PH_RUN) ? gpioOeReq[j]  : 1'b0;
      gpioOut[j] = (phaseIn == PH_RUN) ? gpioOutReq[j] : 1'b0;
    end
  end

  // R4: timer never passes the long window
  a_r4_timer_bound: assert property (@(posedge clk) disable iff (!supplyGood)
    timer <= FAIL_LAST);

  // R8: held reset pins sink on PWM class and float on general class
  a_r8_held_pins: assert property (@(posedge clk) disable iff (!supplyGood)
    (phaseIn == PH_HELD) |-> ((&pwmOe) && (pwmLvl == '0) && (gpioOe == '0)));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       supplyGood,
  input  logic       rstPinN,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  input  seqStat_t   stat,
  output seqCtl_t    ctl,
  output logic [1:0] phase,
  output logic       ready
);

  typedef enum logic [1:0] {S_SUPPLY, S_HOLD, S_INIT, S_RUN} ctlState_e;

  ctlState_e state, nxt;
  logic      softHit;

  assign softHit = cmdValid && (cmdByte == SOFT_RST_CODE);

  always_comb begin
    nxt = state;
    ctl = '0;
    case (state)
      S_SUPPLY: begin
        nxt          = S_INIT;
        ctl.timerClr = 1'b1;
        ctl.failClr  = 1'b1;
      end
      S_HOLD: begin
        if (rstPinN) begin
          nxt          = S_INIT;
          ctl.timerClr = 1'b1;
          ctl.failClr  = 1'b1;
        end
      end
      S_INIT: begin
        if (stat.pinTrip) begin
          nxt = S_HOLD;
        end else if (softHit) begin
          ctl.timerClr = 1'b1;
          ctl.failClr  = 1'b1;
        end else begin
          ctl.failArm = 1'b1;
          if (stat.initDone) nxt = S_RUN;
          else               ctl.timerRun = 1'b1;
        end
      end
      default: begin
        if (stat.pinTrip) begin
          nxt = S_HOLD;
        end else if (softHit) begin
          nxt          = S_INIT;
          ctl.timerClr = 1'b1;
          ctl.failClr  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) begin
      state <= S_SUPPLY;
      ready <= 1'b0;
    end else begin
      state <= nxt;
      ready <= (nxt == S_RUN);
    end
  end

  always_comb begin
    case (state)
      S_SUPPLY: phase = PH_SUPPLY;
      S_RUN:    phase = PH_RUN;
      default:  phase = PH_HELD;
    endcase
  end

  // R12: ready only in run
  a_r12_ready_run: assert property (@(posedge clk) disable iff (!supplyGood)
    ready |-> (phase == PH_RUN));

  // R3: run is entered only after the window expires
  a_r3_run_entry: assert property (@(posedge clk) disable iff (!supplyGood)
    $rose(ready) |-> $past(stat.initDone));

  // R5: held reset entered only through the pin filter
  a_r5_pin_filter: assert property (@(posedge clk) disable iff (!supplyGood)
    ((state == S_HOLD) && ($past(state) != S_HOLD)) |-> $past(stat.pinTrip));

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int CLK_KHZ      = 200000,
  parameter int INIT_MS      = 20,
  parameter int INIT_FAIL_MS = 200,
  parameter int TRST_US      = 2,
  parameter int NUM_PWM      = 4,
  parameter int NUM_GPIO     = 8
) (
  input  logic                clk,
  input  logic                supplyGood,
  input  logic                supplyValid,
  input  logic                rstPinN,
  input  logic                cmdValid,
  input  logic [7:0]          cmdByte,
  input  logic                chkValid,
  input  logic                chkFail,
  input  logic [NUM_PWM-1:0]  pwmReq,
  input  logic [NUM_GPIO-1:0] gpioOeReq,
  input  logic [NUM_GPIO-1:0] gpioOutReq,
  output logic [1:0]          phase,
  output logic                ready,
  output logic [NUM_PWM-1:0]  pwmOe,
  output logic [NUM_PWM-1:0]  pwmLvl,
  output logic [NUM_GPIO-1:0] gpioOe,
  output logic [NUM_GPIO-1:0] gpioOut
);

  localparam int INIT_CYC = CLK_KHZ * INIT_MS;
  localparam int FAIL_CYC = CLK_KHZ * INIT_FAIL_MS;
  localparam int TRST_CYC = (CLK_KHZ * TRST_US) / 1000;

  seqCtl_t  ctl;
  seqStat_t stat;

  rst_seq_ctrl u_ctrl (
    .clk        (clk),
    .supplyGood (supplyGood),
    .rstPinN    (rstPinN),
    .cmdValid   (cmdValid),
    .cmdByte    (cmdByte),
    .stat       (stat),
    .ctl        (ctl),
    .phase      (phase),
    .ready      (ready)
  );

  rst_seq_dp #(
    .INIT_CYC (INIT_CYC),
    .FAIL_CYC (FAIL_CYC),
    .TRST_CYC (TRST_CYC),
    .NUM_PWM  (NUM_PWM),
    .NUM_GPIO (NUM_GPIO)
  ) u_dp (
    .clk        (clk),
    .supplyGood (supplyGood),
    .supplyValid(supplyValid),
    .rstPinN    (rstPinN),
    .chkValid   (chkValid),
    .chkFail    (chkFail),
    .ctl        (ctl),
    .phaseIn    (phase),
    .pwmReq     (pwmReq),
    .gpioOeReq  (gpioOeReq),
    .gpioOutReq (gpioOutReq),
    .stat       (stat),
    .pwmOe      (pwmOe),
    .pwmLvl     (pwmLvl),
    .gpioOe     (gpioOe),
    .gpioOut    (gpioOut)
  );

endmodule

// File: tb/sim_rst_seq_top.sv
`timescale 1ns/1ps
module sim_rst_seq_top;

  localparam int NP = 4;
  localparam int NG = 8;
  localparam int SHORT_WIN = 20;
  localparam int LONG_WIN  = 200;
  localparam int FILT      = 6;

  logic          clk = 1'b0;
  logic          supplyGood = 1'b0, supplyValid = 1'b1, rstPinN = 1'b1;
  logic          cmdValid = 1'b0, chkValid = 1'b0, chkFail = 1'b0;
  logic [7:0]    cmdByte = 8'h00;
  logic [NP-1:0] pwmReq = '0;
  logic [NG-1:0] gpioOeReq = '0, gpioOutReq = '0;
  logic [1:0]    phase;
  logic          ready;
  logic [NP-1:0] pwmOe, pwmLvl;
  logic [NG-1:0] gpioOe, gpioOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rst_seq_top #(
    .CLK_KHZ(1), .INIT_MS(SHORT_WIN), .INIT_FAIL_MS(LONG_WIN),
    .TRST_US(FILT * 1000), .NUM_PWM(NP), .NUM_GPIO(NG)
  ) u0 (
    .clk(clk), .supplyGood(supplyGood), .supplyValid(supplyValid),
    .rstPinN(rstPinN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .chkValid(chkValid), .chkFail(chkFail), .pwmReq(pwmReq),
    .gpioOeReq(gpioOeReq), .gpioOutReq(gpioOutReq), .phase(phase),
    .ready(ready), .pwmOe(pwmOe), .pwmLvl(pwmLvl), .gpioOe(gpioOe),
    .gpioOut(gpioOut)
  );

  function automatic int winLen(bit failed);
    return failed ? LONG_WIN : SHORT_WIN;
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkHeld(string req);
    check(req, "phase", 32'(phase), 32'd1);
    check(req, "ready", 32'(ready), 32'd0);
    check("R8", "pwmOe held", 32'(pwmOe), 32'((1 << NP) - 1));
    check("R8", "pwmLvl held", 32'(pwmLvl), 32'd0);
    check("R8", "gpioOe held", 32'(gpioOe), 32'd0);
  endtask

  task automatic checkRun(string req);
    check(req, "phase", 32'(phase), 32'd2);
    check("R12", "ready", 32'(ready), 32'd1);
    check("R10", "pwmOe run", 32'(pwmOe), 32'((1 << NP) - 1));
    check("R10", "pwmLvl run", 32'(pwmLvl), 32'(pwmReq));
    check("R10", "gpioOe run", 32'(gpioOe), 32'(gpioOeReq));
    check("R10", "gpioOut run", 32'(gpioOut), 32'(gpioOutReq));
  endtask

  task automatic randReq();
    pwmReq     = NP'($urandom);
    gpioOeReq  = NG'($urandom);
    gpioOutReq = NG'($urandom);
    #0.1;
  endtask

  // one soft reset followed by a check report; measures the window
  task automatic softCycle(bit failed);
    int len;
    len = winLen(failed);
    cmdValid = 1'b1; cmdByte = 8'hDB;
    step(1);                         // R6: entry edge
    cmdValid = 1'b0;
    chkValid = 1'b1; chkFail = failed;
    checkHeld("R6");
    step(1);
    chkValid = 1'b0; chkFail = 1'b0;
    step(len - 2);
    checkHeld(failed ? "R4" : "R3");
    step(1);
    randReq();
    checkRun(failed ? "R4" : "R3");
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] badByte;
    void'($urandom(32'd1234));
    #3;
    // R1, R9: supply reset state
    check("R1", "phase", 32'(phase), 32'd0);
    check("R1", "ready", 32'(ready), 32'd0);
    check("R9", "pwmOe", 32'(pwmOe), 32'd0);
    check("R9", "gpioOe", 32'(gpioOe), 32'd0);
    step(2);

    // R2, R3: supply rise and short window
    supplyGood = 1'b1;
    step(1);
    checkHeld("R2");
    step(SHORT_WIN - 1);
    checkHeld("R3");
    step(1);
    randReq();
    checkRun("R3");

    // R6: wrong command bytes have no effect
    for (int k = 0; k < 4; k++) begin
      badByte = 8'($urandom);
      if (badByte == 8'hDB) badByte = 8'h5A;
      cmdValid = 1'b1; cmdByte = badByte;
      step(1);
      cmdValid = 1'b0;
      step(1);
      checkRun("R6");
    end

    // R4, R3: random soft resets with pass or fail reports
    for (int k = 0; k < 6; k++) begin
      softCycle(bit'($urandom % 2));
    end
    softCycle(1'b1);
    softCycle(1'b0);

    // R5: pulse of exactly the filter length is ignored
    rstPinN = 1'b0;
    step(FILT);
    rstPinN = 1'b1;
    step(1);
    checkRun("R5");

    // R5: one edge longer enters held reset
    rstPinN = 1'b0;
    step(FILT);
    checkRun("R5");
    step(1);
    checkHeld("R5");
    step(10);
    checkHeld("R5");
    rstPinN = 1'b1;
    step(1);
    checkHeld("R5");
    step(SHORT_WIN - 1);
    checkHeld("R5");
    step(1);
    randReq();
    checkRun("R5");

    // R7: pin ignored when supply out of range
    supplyValid = 1'b0;
    rstPinN = 1'b0;
    step(30);
    checkRun("R7");
    rstPinN = 1'b1;
    step(1);
    supplyValid = 1'b1;
    step(1);
    checkRun("R7");

    // R11: soft restart in mid window after a fail report
    cmdValid = 1'b1; cmdByte = 8'hDB;
    step(1);
    cmdValid = 1'b0;
    chkValid = 1'b1; chkFail = 1'b1;
    step(1);
    chkValid = 1'b0; chkFail = 1'b0;
    step(8);
    cmdValid = 1'b1;
    step(1);
    cmdValid = 1'b0;
    step(SHORT_WIN - 1);
    checkHeld("R11");
    step(1);
    randReq();
    checkRun("R11");

    // R11: hard reset in mid window restarts too
    cmdValid = 1'b1;
    step(1);
    cmdValid = 1'b0;
    step(5);
    rstPinN = 1'b0;
    step(FILT + 1);
    checkHeld("R11");
    rstPinN = 1'b1;
    step(SHORT_WIN);
    checkHeld("R11");
    step(1);
    checkRun("R11");

    // R1: supply drop acts at once
    @(negedge clk);
    supplyGood = 1'b0;
    #0.5;
    check("R1", "phase drop", 32'(phase), 32'd0);
    check("R1", "ready drop", 32'(ready), 32'd0);
    check("R9", "pwmOe drop", 32'(pwmOe), 32'd0);
    step(3);
    supplyGood = 1'b1;
    step(SHORT_WIN);
    checkHeld("R2");
    step(1);
    checkRun("R2");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule